// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame is kept. The destination address arrives one byte per cycle at the start of the frame. When the frame ends, the block is given the frame length and two error flags. From these it produces a verdict. That verdict depends on a 48-bit station address, a 64-bit multicast hash table and a 5-bit receive mode word. All three are supplied as static inputs by the surrounding receive logic.

The verdict becomes valid one cycle after the end-of-frame strobe. It stays unchanged until the next start-of-frame strobe, and it goes invalid one cycle after that strobe. A second output tells whether an accepted frame matched as a group address (multicast or broadcast) or as a physical address. The block does not check the frame CRC itself. It runs a CRC-32 over the six destination bytes only, to index the hash table.

Top module: `da_filter`

## Requirements
- R1: After synchronous reset, `verdict_valid`, `verdict_accept` and `verdict_group` are all 0.
- R2: One cycle after `frame_end`, `verdict_valid` is 1. The verdict holds stable until `frame_start`, and one cycle after `frame_start` all three verdict outputs are 0.
- R3: The destination byte received first is compared with `station_addr[7:0]`, and byte k is compared with `station_addr[8k+7:8k]`. A destination whose first byte has bit 0 clear is physical. With `rx_mode[2]` (take-all) clear, a physical destination is accepted only if it equals `station_addr`.
- R4: With `rx_mode[2]` set, every physical destination is accepted.
- R5: The all-ones destination is broadcast. It is accepted only when `rx_mode[0]` (take-broadcast) is set, regardless of the hash table.
- R6: A non-broadcast destination whose first byte has bit 0 set is multicast.
  - It is rejected when `rx_mode[1]` (take-multicast) is clear.
  - Otherwise a CRC-32 is run over the six bytes: reflected polynomial 0xEDB88320, seed 0xFFFFFFFF, each byte taken LSB first, no final inversion.
  - Bits [31:26] of that CRC give an index i, and the frame is accepted iff `hash_tbl[i]` is 1. This means bit i%8 of hash byte i/8, where hash byte r is `hash_tbl[8r+7:8r]`.
- R7: A frame whose `frame_len` is below 64 is rejected unless `rx_mode[3]` (keep-short) is set.
- R8: A frame with `crc_err` or `align_err` is rejected unless `rx_mode[4]` (keep-bad) is set.
- R9: Only the first six destination bytes after `frame_start` are used, and later bytes have no effect. A frame that ends with fewer than six bytes received is rejected.
- R10: `verdict_group` is 1 only for an accepted broadcast or multicast frame, and is 0 for an accepted physical match and for any rejected frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mode | input | 5 | Receive mode: [0] take-broadcast, [1] take-multicast, [2] take-all, [3] keep-short, [4] keep-bad |
| station_addr | input | 48 | Station address, first byte in [7:0] |
| hash_tbl | input | 64 | Multicast hash table, eight bytes |
| frame_start | input | 1 | Start-of-frame strobe |
| da_valid | input | 1 | Destination byte valid |
| da_byte | input | 8 | Destination byte |
| frame_end | input | 1 | End-of-frame strobe |
| frame_len | input | 16 | Frame length in bytes, sampled with frame_end |
| crc_err | input | 1 | Frame CRC error, sampled with frame_end |
| align_err | input | 1 | Frame alignment error, sampled with frame_end |
| verdict_valid | output | 1 | Verdict is valid |
| verdict_accept | output | 1 | Frame accepted |
| verdict_group | output | 1 | Accepted as broadcast or multicast |

## Verification
The bench uses the default build: six address bytes, a 64-entry hash table, 16-bit length and a 64-byte minimum. With these values, all 32 receive-mode words can be swept against every address class. Each class is sent with length 63 and 64 and with each error kind, so every acceptance condition and their interaction is reached. A further sweep walks a single set bit through all 64 hash positions for one multicast address. This confirms that exactly the CRC-selected bit admits the frame. Short-address frames and the trailing bytes sent after each address cover the byte-capture limit.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int          OCTET_W    = 8;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

    // Receive mode word; take_bcast is bit 0
    typedef struct packed {
        logic keep_bad;
        logic keep_short;
        logic take_all;
        logic take_mcast;
        logic take_bcast;
    } rx_mode_t;

    // Classification of the captured destination
    typedef struct packed {
        logic complete;
        logic bcast;
        logic group;
        logic phys_hit;
        logic hash_hit;
    } da_class_t;

    // Advance a reflected CRC-32 over one byte, LSB first
    function automatic logic [31:0] crc_octet(input logic [31:0] c_in,
                                              input logic [7:0]  d);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < OCTET_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_R;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dafilt_capture.sv
module dafilt_capture
    import dafilt_pkg::*;
#(
    parameter int NBYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    byte_valid,
    input  logic [OCTET_W-1:0]      byte_in,
    output logic [OCTET_W*NBYTES-1:0] addr,
    output logic [31:0]             crc,
    output logic                    complete
);

    localparam int              CNT_W = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt  <= '0;
            crc  <= CRC_SEED;
            addr <= '0;
        end else if (byte_valid && cnt != LAST) begin
            addr[int'(cnt)*OCTET_W +: OCTET_W] <= byte_in;
            crc  <= crc_octet(crc, byte_in);
            cnt  <= cnt + 1'b1;
        end
    end

    assign complete = (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                               // R9
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (complete && !start) |=> $stable(addr) && $stable(crc));    // R9

endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify
    import dafilt_pkg::*;
#(
    parameter int NBYTES    = 6,
    parameter int HASH_BITS = 64
) (
    input  logic [OCTET_W*NBYTES-1:0] addr,
    input  logic [31:0]               crc,
    input  logic                      complete,
    input  logic [OCTET_W*NBYTES-1:0] station,
    input  logic [HASH_BITS-1:0]      hash_tbl,
    output da_class_t                 cls
);

    localparam int IDX_W = $clog2(HASH_BITS);
    localparam int REGS  = HASH_BITS / OCTET_W;
    localparam int SEL_W = $clog2(REGS);
    localparam int BIT_W = IDX_W - SEL_W;

    logic [OCTET_W-1:0] hash_reg [REGS];
    logic [IDX_W-1:0]   idx;

    for (genvar r = 0; r < REGS; r++) begin : g_hreg
        assign hash_reg[r] = hash_tbl[r*OCTET_W +: OCTET_W];
    end

    assign idx = crc[31 -: IDX_W];

    always_comb begin
        cls          = '0;
        cls.complete = complete;
        cls.bcast    = &addr;
        cls.group    = addr[0];
        cls.phys_hit = (addr == station);
        cls.hash_hit = hash_reg[idx[IDX_W-1 -: SEL_W]][idx[BIT_W-1:0]];
    end

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             eof,
    input  rx_mode_t         mode,
    input  da_class_t        cls,
    input  logic [LEN_W-1:0] len,
    input  logic             crc_err,
    input  logic             align_err,
    output logic             valid,
    output logic             accept,
    output logic             group
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

    logic addr_ok, len_ok, err_ok, ok;

    always_comb begin
        if (!cls.complete)   addr_ok = 1'b0;
        else if (cls.bcast)  addr_ok = mode.take_bcast;
        else if (cls.group)  addr_ok = mode.take_mcast && cls.hash_hit;
        else                 addr_ok = mode.take_all || cls.phys_hit;
        len_ok = (len >= MIN_L) || mode.keep_short;
        err_ok = !(crc_err || align_err) || mode.keep_bad;
        ok     = addr_ok && len_ok && err_ok;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            valid  <= 1'b0;
            accept <= 1'b0;
            group  <= 1'b0;
        end else if (eof) begin
            valid  <= 1'b1;
            accept <= ok;
            group  <= ok && cls.group;
        end
    end

    AST_EOF_VALID: assert property (@(posedge clk) disable iff (rst)
        (eof && !start) |=> valid);                                 // R2
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> !valid && !accept && !group);                     // R2
    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && !eof) |=> $stable(accept) && $stable(group));    // R2
    AST_RUNT_DROP: assert property (@(posedge clk) disable iff (rst)
        (eof && !start && len < MIN_L && !mode.keep_short) |=> !accept); // R7
    AST_ERR_DROP: assert property (@(posedge clk) disable iff (rst)
        (eof && !start && (crc_err || align_err) && !mode.keep_bad) |=> !accept); // R8
    AST_SHORT_DA: assert property (@(posedge clk) disable iff (rst)
        (eof && !start && !cls.complete) |=> !accept);              // R9
    AST_BCAST_GATE: assert property (@(posedge clk) disable iff (rst)
        (eof && !start && cls.complete && cls.bcast && !mode.take_bcast) |=> !accept); // R5
    AST_GROUP_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        group |-> accept && valid);                                 // R10

endmodule

// File: rtl/da_filter.sv
module da_filter
    import dafilt_pkg::*;
#(
    parameter int NBYTES    = 6,
    parameter int HASH_BITS = 64,
    parameter int LEN_W     = 16,
    parameter int MIN_LEN   = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [4:0]                rx_mode,
    input  logic [OCTET_W*NBYTES-1:0] station_addr,
    input  logic [HASH_BITS-1:0]      hash_tbl,
    input  logic                      frame_start,
    input  logic                      da_valid,
    input  logic [OCTET_W-1:0]        da_byte,
    input  logic                      frame_end,
    input  logic [LEN_W-1:0]          frame_len,
    input  logic                      crc_err,
    input  logic                      align_err,
    output logic                      verdict_valid,
    output logic                      verdict_accept,
    output logic                      verdict_group
);

    logic [OCTET_W*NBYTES-1:0] cap_addr;
    logic [31:0]               cap_crc;
    logic                      cap_done;
    da_class_t                 cls;
    rx_mode_t                  mode;

    assign mode = rx_mode_t'(rx_mode);

    dafilt_capture #(.NBYTES(NBYTES)) i_capture (
        .clk        (clk),
        .rst        (rst),
        .start      (frame_start),
        .byte_valid (da_valid),
        .byte_in    (da_byte),
        .addr       (cap_addr),
        .crc        (cap_crc),
        .complete   (cap_done)
    );

    dafilt_classify #(.NBYTES(NBYTES), .HASH_BITS(HASH_BITS)) i_classify (
        .addr     (cap_addr),
        .crc      (cap_crc),
        .complete (cap_done),
        .station  (station_addr),
        .hash_tbl (hash_tbl),
        .cls      (cls)
    );

    dafilt_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_decide (
        .clk       (clk),
        .rst       (rst),
        .start     (frame_start),
        .eof       (frame_end),
        .mode      (mode),
        .cls       (cls),
        .len       (frame_len),
        .crc_err   (crc_err),
        .align_err (align_err),
        .valid     (verdict_valid),
        .accept    (verdict_accept),
        .group     (verdict_group)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !verdict_valid && !verdict_accept && !verdict_group); // R1

endmodule

// File: tb/test_da_filter.sv
module test_da_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rx_mode = '0;
    logic [47:0] station_addr = 48'h9A78_5634_1202;
    logic [63:0] hash_tbl = 64'hF0F0_5A5A_C3C3_1234;
    logic        frame_start = 1'b0;
    logic        da_valid = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        frame_end = 1'b0;
    logic [15:0] frame_len = '0;
    logic        crc_err = 1'b0;
    logic        align_err = 1'b0;
    logic        verdict_valid, verdict_accept, verdict_group;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_filter i_da_filter (
        .clk(clk), .rst(rst), .rx_mode(rx_mode), .station_addr(station_addr),
        .hash_tbl(hash_tbl), .frame_start(frame_start), .da_valid(da_valid),
        .da_byte(da_byte), .frame_end(frame_end), .frame_len(frame_len),
        .crc_err(crc_err), .align_err(align_err), .verdict_valid(verdict_valid),
        .verdict_accept(verdict_accept), .verdict_group(verdict_group)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial CRC over 48 address bits, bit 0 of byte 0 first
    function automatic logic [5:0] hash_index(input logic [47:0] da);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[0] ^ da[i];
            c = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c[31:26];
    endfunction

    function automatic logic expect_accept(input logic [47:0] da, input logic [4:0] m,
                                           input int len, input logic ce, input logic ae,
                                           input int nbytes);
        logic a_ok;
        if (&da)        a_ok = m[0];
        else if (da[0]) a_ok = m[1] && hash_tbl[hash_index(da)];
        else            a_ok = m[2] || (da == station_addr);
        return a_ok && (len >= 64 || m[3]) && (!(ce || ae) || m[4]) && (nbytes >= 6);
    endfunction

    task automatic send_frame(input logic [47:0] da, input int len, input logic ce,
                              input logic ae, input int nbytes, input string tag);
        logic exp_a, exp_g;
        exp_a = expect_accept(da, rx_mode, len, ce, ae, nbytes);
        exp_g = exp_a && da[0];
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        chk("R2 start clears valid", {7'b0, verdict_valid}, 8'h0);
        for (int b = 0; b < nbytes; b++) begin
            da_valid = 1'b1; da_byte = da[b*8 +: 8];
            @(negedge clk);
        end
        if (nbytes >= 6) begin
            for (int b = 0; b < 2; b++) begin   // R9: trailing bytes must be ignored
                da_valid = 1'b1; da_byte = 8'hC5 + 8'(b);
                @(negedge clk);
            end
        end
        da_valid = 1'b0;
        frame_end = 1'b1; frame_len = 16'(len); crc_err = ce; align_err = ae;
        @(negedge clk);
        frame_end = 1'b0; crc_err = 1'b0; align_err = 1'b0; frame_len = 16'd0;
        chk("R2 valid after end", {7'b0, verdict_valid}, 8'h1);
        chk(tag, {7'b0, verdict_accept}, {7'b0, exp_a});
        chk("R10 group flag", {7'b0, verdict_group}, {7'b0, exp_g});
        @(negedge clk); @(negedge clk);
        chk("R2 verdict held", {6'b0, verdict_accept, verdict_valid}, {6'b0, exp_a, 1'b1});
    endtask

    initial begin
        logic [47:0] addrs [5];
        string       kinds [5];
        addrs[0] = 48'h9A78_5634_1202; kinds[0] = "R3 station match";
        addrs[1] = 48'h9A78_5634_1302; kinds[1] = "R4 other unicast";
        addrs[2] = 48'hFFFF_FFFF_FFFF; kinds[2] = "R5 broadcast";
        addrs[3] = 48'h0100_005E_0001; kinds[3] = "R6 multicast a";
        addrs[4] = 48'h2233_4455_6633; kinds[4] = "R6 multicast b";

        repeat (3) @(negedge clk);
        chk("R1 reset valid",  {7'b0, verdict_valid},  8'h0);
        chk("R1 reset accept", {7'b0, verdict_accept}, 8'h0);
        chk("R1 reset group",  {7'b0, verdict_group},  8'h0);
        rst = 1'b0;

        // Sweep of every mode word against every address class, length and error kind
        for (int m = 0; m < 32; m++) begin
            rx_mode = 5'(m);
            for (int a = 0; a < 5; a++)
                for (int l = 63; l <= 64; l++)
                    for (int e = 0; e < 3; e++) begin
                        string tag;
                        if (e != 0)     tag = "R8 error gate";
                        else if (l < 64) tag = "R7 short gate";
                        else            tag = kinds[a];
                        send_frame(addrs[a], l, e == 1, e == 2, 6, tag);
                    end
        end

        // Hash table: walk a single set bit across all 64 positions
        rx_mode = 5'b00010;
        for (int k = 0; k < 64; k++) begin
            hash_tbl = 64'd1 << k;
            send_frame(addrs[3], 100, 1'b0, 1'b0, 6, "R6 hash bit select");
        end
        hash_tbl = 64'hF0F0_5A5A_C3C3_1234;

        // Incomplete destination address is rejected even with all modes on
        rx_mode = 5'b11111;
        for (int n = 0; n < 6; n++)
            send_frame(addrs[0], 100, 1'b0, 1'b0, n, "R9 short address");

        // Reset in the middle of a held verdict
        send_frame(addrs[0], 100, 1'b0, 1'b0, 6, "R3 station match");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset clears verdict",
            {5'b0, verdict_valid, verdict_accept, verdict_group}, 8'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule